// File: doc/BRIEF.md
# Emulated UART Transmit Status Logic

This block keeps the transmit-side status of a UART whose serial engine is emulated by a local controller. A host places characters into transmit storage: a single holding register in single-buffer mode, or a first-in first-out queue of `DEPTH` entries in queue mode. The controller removes them one at a time for transmission. The block does not shift any bits onto a line. What it keeps is storage occupancy, the holding-empty flag, and the transmitter-empty flag.

The holding-empty flag exists in two copies. The controller copy follows occupancy without delay. The host copy can be held back by a programmable down-counter, so that the host sees the register empty only after a chosen number of cycles, which mimics real transmit time. A host write cancels the pending delay. While the controller is halted, a notify-on-access enable forces the host copy low, so the host cannot overrun the holding register. The transmitter-empty flag is normally written by the controller. In double-buffer mode, hardware derives it from the storage and from the controller's shift-stage busy indication.

Top module: `utx_tx_status`

## Requirements
- R1: After synchronous reset the storage is empty (`tx_level` = 0), and `ctrl_thre`, `host_thre` and `temt` are all 1.
- R2: The storage capacity is 1 entry when `fifo_mode` = 0 and `DEPTH` entries when `fifo_mode` = 1. A host write when the storage is at capacity is dropped and leaves the contents unchanged. `ctrl_rd_data` always shows the oldest stored byte, and bytes leave in the order in which they were written.
- R3: `ctrl_thre` equals 1 exactly when the storage is empty. It falls at the clock edge that accepts a write into empty storage, and it rises at the edge of the controller read that removes the last byte.
- R4: When the delay timer is not in use (`tmr_en` = 0, or `tmr_load` = 0 at the emptying edge), `host_thre` rises at the same edge as `ctrl_thre`.
- R5: When `tmr_en` = 1 and `tmr_load` = N > 0 at the emptying edge, `host_thre` stays 0 for that edge and rises exactly N clock edges later.
- R6: An accepted host write clears `host_thre` and `ctrl_thre` at its edge and cancels a pending delay. `host_thre` then stays 0 until the next emptying.
- R7: While `halt` = 1 and `notify_en` = 1, `host_thre` is 0, combinationally. When either input drops, `host_thre` returns to its underlying value at once.
- R8: With `dbl_buf_en` = 0, `temt` changes only through a controller write (`ctrl_temt_we` = 1 loads `ctrl_temt_val` at the edge). Host writes and reads leave it unchanged.
- R9: With `dbl_buf_en` = 1, `temt` is registered as (storage empty after this edge) AND NOT `shift_busy`, and controller writes to `temt` are ignored.
- R10: A change of `fifo_mode` discards the storage contents at that edge, and any host write in the same cycle is dropped. A controller read of empty storage has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe into transmit storage |
| host_wr_data | input | DW | Host write byte |
| ctrl_rd_en | input | 1 | Controller removes the oldest byte |
| ctrl_rd_data | output | DW | Oldest stored byte |
| fifo_mode | input | 1 | 0 single holding register, 1 queue of DEPTH |
| tmr_en | input | 1 | Enables the host-side empty delay |
| tmr_load | input | TW | Delay length in cycles |
| dbl_buf_en | input | 1 | Hardware-driven transmitter-empty |
| shift_busy | input | 1 | Controller shift stage holds a character |
| ctrl_temt_we | input | 1 | Controller write strobe for transmitter-empty |
| ctrl_temt_val | input | 1 | Value written to transmitter-empty |
| halt | input | 1 | Controller halted (power-down) |
| notify_en | input | 1 | Notify-on-access enable; with halt forces host_thre low |
| host_thre | output | 1 | Host-visible holding-empty flag (delayed) |
| ctrl_thre | output | 1 | Controller-visible holding-empty flag (immediate) |
| temt | output | 1 | Transmitter-empty flag |
| tx_level | output | $clog2(DEPTH+1) | Stored byte count |

## Verification
A corrupted occupancy count shows up on the very next edge, as a `tx_level` or `ctrl_rd_data` mismatch or as `ctrl_thre` disagreeing with the level. A read pointer that has slipped reorders the bytes drained from a full queue. A wrong delay counter changes the edge at which `host_thre` rises relative to `ctrl_thre`, so the bench samples every cycle of the delay window and catches an off-by-one within N+1 cycles. A missed cancel shows as `host_thre` rising while bytes are still stored.

// File: rtl/utx_pkg.sv
package utx_pkg;

    typedef enum logic {
        BUF_SINGLE = 1'b0,
        BUF_QUEUE  = 1'b1
    } buf_mode_e;

    // Per-cycle storage events handed to the status logic
    typedef struct packed {
        logic accepted;   // host byte stored this edge
        logic popped;     // controller removed a byte this edge
        logic go_empty;   // occupancy becomes zero at this edge
        logic empty_nxt;  // occupancy after this edge is zero
    } store_evt_t;

    function automatic logic both_idle(input logic empty_nxt, input logic busy);
        return empty_nxt && !busy;
    endfunction

endpackage

// File: rtl/utx_store.sv
module utx_store
    import utx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [DW-1:0]   wr_data,
    input  logic            rd_en,
    input  buf_mode_e       mode,
    output logic [DW-1:0]   rd_data,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output store_evt_t      evt
);
    localparam int LW = $clog2(DEPTH + 1);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [LW-1:0] lvl_q, lvl_nxt, cap;
    buf_mode_e     mode_q;
    logic          flush, accept, pop;

    assign cap    = (mode == BUF_QUEUE) ? LW'(DEPTH) : LW'(1);
    assign flush  = (mode != mode_q);
    assign accept = wr_en && !flush && (lvl_q < cap);
    assign pop    = rd_en && !flush && (lvl_q != '0);

    always_comb begin
        if (flush)
            lvl_nxt = '0;
        else if (accept && !pop)
            lvl_nxt = lvl_q + LW'(1);
        else if (pop && !accept)
            lvl_nxt = lvl_q - LW'(1);
        else
            lvl_nxt = lvl_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
            mode_q <= mode;
        end else begin
            mode_q <= mode;
            lvl_q  <= lvl_nxt;
            if (flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (accept) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + PW'(1);
                if (pop)    rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + PW'(1);
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (accept && wr_ptr == PW'(g))
                mem[g] <= wr_data;
        end
    end

    assign rd_data       = mem[rd_ptr];
    assign level         = lvl_q;
    assign evt.accepted  = accept;
    assign evt.popped    = pop;
    assign evt.empty_nxt = (lvl_nxt == '0);
    assign evt.go_empty  = (lvl_q != '0) && (lvl_nxt == '0);

endmodule

// File: rtl/utx_thre_delay.sv
module utx_thre_delay
    import utx_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  store_evt_t    evt,
    input  logic          tmr_en,
    input  logic [TW-1:0] tmr_load,
    output logic          hbit
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hbit  <= 1'b1;
            cnt_q <= '0;
        end else if (evt.accepted) begin
            hbit  <= 1'b0;
            cnt_q <= '0;
        end else if (evt.go_empty) begin
            if (tmr_en && tmr_load != '0) begin
                cnt_q <= tmr_load;
            end else begin
                hbit <= 1'b1;
            end
        end else if (cnt_q != '0) begin
            if (cnt_q == TW'(1)) hbit <= 1'b1;
            cnt_q <= cnt_q - TW'(1);
        end
    end

endmodule

// File: rtl/utx_tx_status.sv
module utx_tx_status
    import utx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int TW    = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       host_wr_en,
    input  logic [DW-1:0]              host_wr_data,
    input  logic                       ctrl_rd_en,
    output logic [DW-1:0]              ctrl_rd_data,
    input  logic                       fifo_mode,
    input  logic                       tmr_en,
    input  logic [TW-1:0]              tmr_load,
    input  logic                       dbl_buf_en,
    input  logic                       shift_busy,
    input  logic                       ctrl_temt_we,
    input  logic                       ctrl_temt_val,
    input  logic                       halt,
    input  logic                       notify_en,
    output logic                       host_thre,
    output logic                       ctrl_thre,
    output logic                       temt,
    output logic [$clog2(DEPTH+1)-1:0] tx_level
);
    store_evt_t evt;
    buf_mode_e  mode;
    logic       hbit;
    logic       temt_q;

    assign mode = fifo_mode ? BUF_QUEUE : BUF_SINGLE;

    utx_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (host_wr_en),
        .wr_data (host_wr_data),
        .rd_en   (ctrl_rd_en),
        .mode    (mode),
        .rd_data (ctrl_rd_data),
        .level   (tx_level),
        .evt     (evt)
    );

    utx_thre_delay #(.TW(TW)) u_delay (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .tmr_en   (tmr_en),
        .tmr_load (tmr_load),
        .hbit     (hbit)
    );

    always_ff @(posedge clk) begin
        if (rst)
            temt_q <= 1'b1;
        else if (dbl_buf_en)
            temt_q <= both_idle(evt.empty_nxt, shift_busy);
        else if (ctrl_temt_we)
            temt_q <= ctrl_temt_val;
    end

    assign ctrl_thre = (tx_level == '0);
    assign host_thre = hbit && !(halt && notify_en);
    assign temt      = temt_q;

endmodule

// File: rtl/utx_tx_status_chk.sv
module utx_tx_status_chk #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int TW    = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       host_wr_en,
    input logic                       fifo_mode,
    input logic                       tmr_en,
    input logic [TW-1:0]              tmr_load,
    input logic                       dbl_buf_en,
    input logic                       shift_busy,
    input logic                       halt,
    input logic                       notify_en,
    input logic                       host_thre,
    input logic                       ctrl_thre,
    input logic                       temt,
    input logic [$clog2(DEPTH+1)-1:0] tx_level
);
    localparam int LW = $clog2(DEPTH + 1);

    // R2
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        tx_level <= LW'(DEPTH));

    // R6
    wr_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr_en && tx_level == '0 && fifo_mode == $past(fifo_mode))
        |=> (!ctrl_thre && !host_thre));

    // R7
    halt_force_chk: assert property (@(posedge clk) disable iff (rst)
        (halt && notify_en) |-> !host_thre);

    // R4
    no_delay_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(ctrl_thre) && (!$past(tmr_en) || $past(tmr_load) == '0)
         && !(halt && notify_en)) |-> host_thre);

    // R5
    host_lags_chk: assert property (@(posedge clk) disable iff (rst)
        host_thre |-> ctrl_thre);

    // R9
    dbl_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (dbl_buf_en && shift_busy) |=> !temt);

endmodule

bind utx_tx_status utx_tx_status_chk #(.DEPTH(DEPTH), .DW(DW), .TW(TW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_wr_en (host_wr_en),
    .fifo_mode  (fifo_mode),
    .tmr_en     (tmr_en),
    .tmr_load   (tmr_load),
    .dbl_buf_en (dbl_buf_en),
    .shift_busy (shift_busy),
    .halt       (halt),
    .notify_en  (notify_en),
    .host_thre  (host_thre),
    .ctrl_thre  (ctrl_thre),
    .temt       (temt),
    .tx_level   (tx_level)
);

// File: tb/utx_tx_status_tb.sv
module utx_tx_status_tb;
    localparam int DEPTH = 16;
    localparam int DW    = 8;
    localparam int TW    = 8;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst;
    logic          host_wr_en, ctrl_rd_en, fifo_mode, tmr_en, dbl_buf_en;
    logic          shift_busy, ctrl_temt_we, ctrl_temt_val, halt, notify_en;
    logic [DW-1:0] host_wr_data, ctrl_rd_data;
    logic [TW-1:0] tmr_load;
    logic          host_thre, ctrl_thre, temt;
    logic [LW-1:0] tx_level;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    utx_tx_status #(.DEPTH(DEPTH), .DW(DW), .TW(TW)) u_dut (
        .clk(clk), .rst(rst),
        .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
        .ctrl_rd_en(ctrl_rd_en), .ctrl_rd_data(ctrl_rd_data),
        .fifo_mode(fifo_mode), .tmr_en(tmr_en), .tmr_load(tmr_load),
        .dbl_buf_en(dbl_buf_en), .shift_busy(shift_busy),
        .ctrl_temt_we(ctrl_temt_we), .ctrl_temt_val(ctrl_temt_val),
        .halt(halt), .notify_en(notify_en),
        .host_thre(host_thre), .ctrl_thre(ctrl_thre), .temt(temt),
        .tx_level(tx_level)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic hwrite(input logic [DW-1:0] d);
        host_wr_en = 1'b1; host_wr_data = d;
        tick();
        host_wr_en = 1'b0;
    endtask

    task automatic cread();
        ctrl_rd_en = 1'b1;
        tick();
        ctrl_rd_en = 1'b0;
    endtask

    initial begin
        rst = 1'b1; host_wr_en = 0; host_wr_data = '0; ctrl_rd_en = 0;
        fifo_mode = 0; tmr_en = 0; tmr_load = '0; dbl_buf_en = 0; shift_busy = 0;
        ctrl_temt_we = 0; ctrl_temt_val = 0; halt = 0; notify_en = 0;
        tick(); tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 level", int'(tx_level), 0);
        chk("R1 ctrl_thre", int'(ctrl_thre), 1);
        chk("R1 host_thre", int'(host_thre), 1);
        chk("R1 temt", int'(temt), 1);

        // R3 / R6 single-buffer write, R2 drop on full
        hwrite(8'hA5);
        chk("R3 ctrl_thre low after write", int'(ctrl_thre), 0);
        chk("R6 host_thre low after write", int'(host_thre), 0);
        chk("R2 level 1", int'(tx_level), 1);
        hwrite(8'h3C);
        chk("R2 single full drop level", int'(tx_level), 1);
        chk("R2 single full drop data", int'(ctrl_rd_data), 'hA5);
        chk("R8 temt unchanged by host write", int'(temt), 1);
        // R4 no timer: both rise together
        cread();
        chk("R3 ctrl_thre rises on last read", int'(ctrl_thre), 1);
        chk("R4 host_thre rises same edge", int'(host_thre), 1);
        // R10 read of empty storage
        cread();
        chk("R10 empty read level", int'(tx_level), 0);
        chk("R10 empty read ctrl_thre", int'(ctrl_thre), 1);

        // R5 delay sweep over several lengths
        tmr_en = 1'b1;
        for (int n = 1; n <= 6; n++) begin
            tmr_load = TW'(n);
            hwrite(8'(n));
            cread();
            chk("R5 ctrl_thre immediate", int'(ctrl_thre), 1);
            chk("R5 host_thre held at empty edge", int'(host_thre), 0);
            for (int k = 1; k <= n + 1; k++) begin
                tick();
                chk($sformatf("R5 n=%0d k=%0d", n, k), int'(host_thre), (k >= n) ? 1 : 0);
            end
        end
        // R4 load zero with timer enabled
        tmr_load = '0;
        hwrite(8'h11);
        cread();
        chk("R4 zero load immediate", int'(host_thre), 1);

        // R6 cancel pending delay
        tmr_load = TW'(4);
        hwrite(8'h22);
        cread();
        tick(); tick();
        hwrite(8'h33);
        chk("R6 cancel ctrl_thre", int'(ctrl_thre), 0);
        for (int k = 0; k < 8; k++) begin
            tick();
            chk("R6 host_thre stays low", int'(host_thre), 0);
        end
        cread();
        for (int k = 0; k < 4; k++) tick();
        chk("R5 delay after cancel", int'(host_thre), 1);
        tmr_en = 1'b0;

        // R7 halt override, combinational
        halt = 1'b1; notify_en = 1'b0; #1;
        chk("R7 halt alone", int'(host_thre), 1);
        notify_en = 1'b1; #1;
        chk("R7 forced low", int'(host_thre), 0);
        halt = 1'b0; #1;
        chk("R7 released", int'(host_thre), 1);
        notify_en = 1'b0;

        // R10 mode change to queue mode, R2 fill/drain sweep
        fifo_mode = 1'b1;
        tick();
        chk("R10 switch level", int'(tx_level), 0);
        for (int i = 0; i < DEPTH; i++) begin
            hwrite(8'(i * 7 + 3));
            chk("R2 queue fill level", int'(tx_level), i + 1);
        end
        hwrite(8'hFF);
        chk("R2 queue full drop", int'(tx_level), DEPTH);
        for (int i = 0; i < DEPTH; i++) begin
            chk("R2 queue order", int'(ctrl_rd_data), (i * 7 + 3) & 8'hFF);
            chk("R3 ctrl_thre while stored", int'(ctrl_thre), 0);
            cread();
        end
        chk("R3 queue drained", int'(ctrl_thre), 1);
        chk("R4 queue drained host", int'(host_thre), 1);
        // R10 mode change discards contents and a same-cycle write
        hwrite(8'h01); hwrite(8'h02); hwrite(8'h03);
        fifo_mode = 1'b0;
        host_wr_en = 1'b1; host_wr_data = 8'h44;
        tick();
        host_wr_en = 1'b0;
        chk("R10 flush level", int'(tx_level), 0);
        chk("R10 flush ctrl_thre", int'(ctrl_thre), 1);

        // R8 explicit temt writes
        ctrl_temt_we = 1'b1; ctrl_temt_val = 1'b0; tick();
        chk("R8 temt write 0", int'(temt), 0);
        ctrl_temt_we = 1'b0;
        hwrite(8'h55); cread();
        chk("R8 temt held", int'(temt), 0);
        ctrl_temt_we = 1'b1; ctrl_temt_val = 1'b1; tick();
        chk("R8 temt write 1", int'(temt), 1);
        ctrl_temt_val = 1'b0; tick();
        ctrl_temt_we = 1'b0;

        // R9 double-buffer mode
        dbl_buf_en = 1'b1; tick();
        chk("R9 idle sets temt", int'(temt), 1);
        ctrl_temt_we = 1'b1; ctrl_temt_val = 1'b0; tick();
        chk("R9 controller write ignored", int'(temt), 1);
        ctrl_temt_we = 1'b0;
        hwrite(8'h66);
        chk("R9 stored byte clears temt", int'(temt), 0);
        shift_busy = 1'b1;
        cread();
        chk("R9 shift busy keeps temt low", int'(temt), 0);
        shift_busy = 1'b0; tick();
        chk("R9 both idle sets temt", int'(temt), 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule